// File: doc/BRIEF.md
# Four-Function Arithmetic/Logic Unit

This block combines two operand words under a two-bit operation code. It can add, subtract, take the bitwise AND or take the bitwise OR. Both arithmetic operations share one ripple chain of single-bit full adders. To subtract, each bit of the second operand goes through an exclusive-OR gate that inverts it, and the chain's first carry-in is set to one, so the chain forms the two's-complement difference.

A selector picks the result word for the requested operation and derives three flags from it: carry-out, signed overflow and zero. Overflow is found by comparing the carry entering the top bit with the carry leaving it. Result and flags are captured in one output register, so each answer appears one clock after its operands. The width is a parameter with a default of 8.

Top module: `quad_alu`

## Requirements
- R1: With op code 2'b00 (add), the result is (A + B) mod 2^WIDTH, and carry is the carry leaving the top bit of A + B.
- R2: With op code 2'b01 (subtract), the result is (A - B) mod 2^WIDTH. Carry is the carry leaving the top bit of A + ~B + 1, which is 1 exactly when A >= B unsigned.
- R3: With op code 2'b10, the result is the bitwise AND of A and B.
- R4: With op code 2'b11, the result is the bitwise OR of A and B.
- R5: For add and subtract, overflow is 1 exactly when the carry entering the top bit differs from the carry leaving it. This is the case exactly when the true two's-complement sum or difference lies outside the signed range of WIDTH bits.
- R6: For the AND and OR op codes, carry and overflow are both 0.
- R7: For every op code, zero is 1 exactly when all result bits are 0.
- R8: Result and flags appear on the outputs at the first rising clock edge after the operands and op code are presented, and they hold until the next edge. While the active-low reset is asserted, result, carry and overflow are 0 and zero is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; output register updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| opa_i | input | WIDTH | First operand A |
| opb_i | input | WIDTH | Second operand B |
| op_i | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 OR |
| result_o | output | WIDTH | Registered result word |
| carry_o | output | 1 | Registered carry out of the top adder stage (0 for logic ops) |
| overflow_o | output | 1 | Registered signed-overflow flag (0 for logic ops) |
| zero_o | output | 1 | Registered flag, 1 when the result word is all zeros |

## Verification
The hardest condition to reach is a disagreement between the carries around the top stage. It needs two same-signed operands whose magnitudes together cross the signed limit, or, for subtraction, two operands of opposite sign. Ordinary random operands at wide widths seldom land on the exact boundary values. The bench therefore runs the unit at a width of four and steps through every operand pair under all four op codes, which hits every carry combination at the top stage. It then adds directed boundary cases such as the most positive value plus one and the most negative value minus one, along with seeded random vectors.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_AND = 2'b10,
        ALU_OR  = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
    } alu_flags_t;

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    logic half_x;

    assign half_x = a_i ^ b_i;
    assign s_o    = half_x ^ c_i;
    assign c_o    = (a_i & b_i) | (half_x & c_i);

endmodule

// File: rtl/addsub_chain.sv
module addsub_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             cmsb_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   carry;

    // carry-in of stage 0 supplies the +1 of the two's complement
    assign carry[0] = sub_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        // conditional inverter on the second operand
        assign b_eff[i] = b_i[i] ^ sub_i;

        fa_cell u_fa (
            .a_i (a_i[i]),
            .b_i (b_eff[i]),
            .c_i (carry[i]),
            .s_o (sum_o[i]),
            .c_o (carry[i+1])
        );
    end

    assign cout_o = carry[WIDTH];
    assign cmsb_o = carry[MSB];

endmodule

// File: rtl/result_mux.sv
module result_mux
    import quad_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             cout_i,
    input  logic             cmsb_i,
    output logic [WIDTH-1:0] res_o,
    output alu_flags_t       flags_o
);

    always_comb begin
        res_o         = sum_i;
        flags_o.carry = 1'b0;
        flags_o.ovf   = 1'b0;
        unique case (op_i)
            ALU_ADD, ALU_SUB: begin
                res_o         = sum_i;
                flags_o.carry = cout_i;
                flags_o.ovf   = cout_i ^ cmsb_i;
            end
            ALU_AND: res_o = a_i & b_i;
            ALU_OR:  res_o = a_i | b_i;
            default: res_o = sum_i;
        endcase
        flags_o.zero = ~|res_o;
    end

endmodule

// File: rtl/quad_alu.sv
module quad_alu
    import quad_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             overflow_o,
    output logic             zero_o
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        alu_flags_t       flags;
    } out_t;

    alu_op_e          op_sel;
    logic             sub_en;
    logic [WIDTH-1:0] sum_w;
    logic             cout_w;
    logic             cmsb_w;
    logic [WIDTH-1:0] res_w;
    alu_flags_t       flags_w;
    out_t             out_d;
    out_t             out_q;

    assign op_sel = alu_op_e'(op_i);
    assign sub_en = (op_sel == ALU_SUB);

    addsub_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .sub_i  (sub_en),
        .sum_o  (sum_w),
        .cout_o (cout_w),
        .cmsb_o (cmsb_w)
    );

    result_mux #(.WIDTH(WIDTH)) u_mux (
        .op_i    (op_sel),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .sum_i   (sum_w),
        .cout_i  (cout_w),
        .cmsb_i  (cmsb_w),
        .res_o   (res_w),
        .flags_o (flags_w)
    );

    always_comb begin
        out_d       = out_q;
        out_d.res   = res_w;
        out_d.flags = flags_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q.res         <= '0;
            out_q.flags.carry <= 1'b0;
            out_q.flags.ovf   <= 1'b0;
            out_q.flags.zero  <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o   = out_q.res;
    assign carry_o    = out_q.flags.carry;
    assign overflow_o = out_q.flags.ovf;
    assign zero_o     = out_q.flags.zero;

    // R1: the ripple chain's sum agrees with a behavioural sum one cycle later
    a_r1_add_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 2'b00) |=> (result_o == WIDTH'($past(opa_i) + $past(opb_i))));

    // R2: subtraction through the inverted operand matches a behavioural difference
    a_r2_sub_diff: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 2'b01) |=> (result_o == WIDTH'($past(opa_i) - $past(opb_i))));

    // R5: carry-based overflow agrees with the operand/result sign rule for add
    a_r5_add_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 2'b00) |=> (overflow_o ==
            (($past(opa_i[MSB]) == $past(opb_i[MSB])) &&
             (result_o[MSB] != $past(opa_i[MSB])))));

    // R5: same cross-check for subtract
    a_r5_sub_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 2'b01) |=> (overflow_o ==
            (($past(opa_i[MSB]) != $past(opb_i[MSB])) &&
             (result_o[MSB] != $past(opa_i[MSB])))));

    // R6: logic operations leave both arithmetic flags clear
    a_r6_logic_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i[1] |=> (!carry_o && !overflow_o));

    // R7: zero flag tracks the registered result word
    a_r7_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_o == (result_o == '0));

endmodule

// File: tb/quad_alu_tb_top.sv
module quad_alu_tb_top;

    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;
    localparam int SMAX = (1 << (W - 1)) - 1;
    localparam int SMIN = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] result;
    logic         carry;
    logic         overflow;
    logic         zero;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    quad_alu #(.WIDTH(W)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .opa_i      (opa),
        .opb_i      (opb),
        .op_i       (op),
        .result_o   (result),
        .carry_o    (carry),
        .overflow_o (overflow),
        .zero_o     (zero)
    );

    task automatic check_eq(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (a=%0d b=%0d op=%0d)",
                     tag, what, act, exp, opa, opb, op);
        end
    endtask

    function automatic int to_signed(int v);
        return (v > SMAX) ? v - (1 << W) : v;
    endfunction

    // returns {result, carry, overflow, zero} packed into an int
    function automatic int ref_model(int a, int b, int o);
        int r = 0;
        int c = 0;
        int v = 0;
        int full;
        int s;
        case (o)
            0: begin
                full = a + b;
                r = full & MASK;
                c = (full >> W) & 1;
                s = to_signed(a) + to_signed(b);
                v = (s > SMAX || s < SMIN) ? 1 : 0;
            end
            1: begin
                full = a + ((~b) & MASK) + 1;
                r = full & MASK;
                c = (full >> W) & 1;
                s = to_signed(a) - to_signed(b);
                v = (s > SMAX || s < SMIN) ? 1 : 0;
            end
            2: r = a & b;
            default: r = a | b;
        endcase
        return (r << 3) | (c << 2) | (v << 1) | ((r == 0) ? 1 : 0);
    endfunction

    // called at a falling edge: drive, wait one cycle, compare at the next falling edge
    task automatic apply(int a, int b, int o);
        int e;
        string rtag;
        opa = a[W-1:0];
        opb = b[W-1:0];
        op  = o[1:0];
        @(negedge clk);
        e = ref_model(a, b, o);
        case (o)
            0: rtag = "R1";
            1: rtag = "R2";
            2: rtag = "R3";
            default: rtag = "R4";
        endcase
        check_eq(rtag, "result", int'(result), e >> 3);
        check_eq((o < 2) ? rtag : "R6", "carry", int'(carry), (e >> 2) & 1);
        check_eq((o < 2) ? "R5" : "R6", "overflow", int'(overflow), (e >> 1) & 1);
        check_eq("R7", "zero", int'(zero), e & 1);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250714));

        // R8 reset state, with inputs that would otherwise give a nonzero sum
        opa = 4'd5;
        opb = 4'd6;
        op  = 2'b00;
        @(negedge clk);
        @(negedge clk);
        check_eq("R8", "reset result", int'(result), 0);
        check_eq("R8", "reset carry", int'(carry), 0);
        check_eq("R8", "reset overflow", int'(overflow), 0);
        check_eq("R8", "reset zero", int'(zero), 1);
        rst_n = 1'b1;

        // R8 one-cycle latency: output holds the old answer until the edge
        apply(1, 1, 0);
        opa = 4'd3;
        opb = 4'd4;
        #1;
        check_eq("R8", "held before edge", int'(result), 2);
        @(negedge clk);
        check_eq("R8", "after edge", int'(result), 7);

        // directed corners
        apply(7, 1, 0);    // R5 positive overflow on add
        apply(8, 15, 0);   // R5 negative overflow on add, carry out
        apply(8, 8, 0);    // R1 wrap to zero with carry, R7
        apply(0, 0, 1);    // R2 carry set, R7 zero
        apply(0, 1, 1);    // R2 borrow, result all ones
        apply(8, 1, 1);    // R5 overflow on subtract
        apply(7, 15, 1);   // R5 overflow on subtract, positive side
        apply(15, 15, 2);  // R3, R6
        apply(5, 10, 2);   // R3 zero result, R7
        apply(0, 0, 3);    // R4 zero result, R7
        apply(15, 1, 3);   // R4, R6

        // exhaustive sweep at width 4
        for (int o = 0; o < 4; o++) begin
            for (int a = 0; a <= MASK; a++) begin
                for (int b = 0; b <= MASK; b++) begin
                    apply(a, b, o);
                end
            end
        end

        // seeded random mix
        for (int n = 0; n < 400; n++) begin
            apply(int'($urandom & MASK), int'($urandom & MASK), int'($urandom & 3));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule